// File: doc/BRIEF.md
# Two-Write Two-Read Replicated-Bank Memory

This block is a synchronous memory that accepts two independent writes and serves two independent reads in every cycle of a single clock, with no faster internal clock. It is intended for datapaths such as read-modify-write pipelines, where two producers and two consumers share one table. Every cycle, each writer may store one word and each reader receives one word.

The storage is split into four plain one-write one-read banks. There is one bank for each pairing of a writer with a reader. A writer places its word into both of its banks at the same address. A reader fetches the same address from the two banks that feed it. It then has to decide which of the two candidate words is current.

That decision is made from two one-bit ownership tables, one per writer. When writer A stores, it copies writer B's bit at that address into its own table. When writer B stores, it saves the inverse of writer A's bit. A reader that finds the two bits equal takes the word from A's bank, and one that finds them different takes the word from B's bank. Because each table has a single writer, the ownership record never needs a port shared by both writers. Read data is registered, with one cycle of latency. A read issued in the same cycle as a write to the same address returns the value held before that write.

Top module: `repl_bank_ram`

## Requirements
- R1: After reset every location reads as zero on both read ports until it is written.
- R2: A read address presented before a clock edge yields its data on the read output after that edge, one cycle of latency.
- R3: A word stored through write port A is returned by both read ports on any later read of that address.
- R4: A word stored through write port B is returned by both read ports on any later read of that address.
- R5: When both writers store to one address in different cycles, reads return the word from whichever store happened last.
- R6: A read in the same cycle as a write to that address returns the value held before the write.
- R7: A write port whose enable is low leaves the memory unchanged.
- R8: Both writers may store in the same cycle to different addresses, and both words are kept. Both writers storing to one address in the same cycle is illegal.
- R9: The two read ports use independent addresses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Active-low synchronous reset, clears contents |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | ADDR_W | Write port A address |
| wa_data | input | DATA_W | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | ADDR_W | Write port B address |
| wb_data | input | DATA_W | Write port B data |
| rc_addr | input | ADDR_W | Read port C address |
| rc_data | output | DATA_W | Read port C data, registered |
| rd_addr | input | ADDR_W | Read port D address |
| rd_data | output | DATA_W | Read port D data, registered |

## Verification
The hardest case to reach is an address whose ownership has changed hands several times, with the ownership bits settled in each of their four combinations. A fault in the inversion or the comparison shows up only after a specific sequence of A and B stores to that address. The directed stimulus alternates the writers on one address and reads it between the stores. A long random phase on a 16-entry space then makes both writers hit the same locations repeatedly, while reads often coincide with writes to the same address.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
   typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;

   // Equal ownership bits mean writer A stored last.
   function automatic side_e pick_side(input logic bit_a, input logic bit_b);
      return (bit_a == bit_b) ? SIDE_A : SIDE_B;
   endfunction
endpackage

// File: rtl/rbr_bank.sv
module rbr_bank #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rd_data <= '0;
      end else begin
         rd_data <= mem[rd_addr];
         if (wr_en) mem[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/rbr_side_store.sv
module rbr_side_store #(
   parameter int DEPTH  = 16,
   parameter bit INVERT = 1'b0,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              peer_bit,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic              peek_bit,
   input  logic [ADDR_W-1:0] rc_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rc_bit,
   output logic              rd_bit
);
   logic mem [DEPTH];
   logic new_bit;

   // Unregistered lookup for the other writer.
   assign peek_bit = mem[peek_addr];

   generate
      if (INVERT) begin : g_inv
         assign new_bit = ~peer_bit;
      end else begin : g_copy
         assign new_bit = peer_bit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 1'b0;
         rc_bit <= 1'b0;
         rd_bit <= 1'b0;
      end else begin
         rc_bit <= mem[rc_addr];
         rd_bit <= mem[rd_addr];
         if (wr_en) mem[wr_addr] <= new_bit;
      end
   end
endmodule

// File: rtl/rbr_read_sel.sv
module rbr_read_sel
   import rbr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] word_a,
   input  logic [DATA_W-1:0] word_b,
   input  logic              bit_a,
   input  logic              bit_b,
   output logic [DATA_W-1:0] sel_data
);
   always_comb begin
      if (pick_side(bit_a, bit_b) == SIDE_A) sel_data = word_a;
      else                                   sel_data = word_b;
   end
endmodule

// File: rtl/repl_bank_ram.sv
module repl_bank_ram #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wa_en,
   input  logic [ADDR_W-1:0] wa_addr,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [ADDR_W-1:0] wb_addr,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [ADDR_W-1:0] rc_addr,
   output logic [DATA_W-1:0] rc_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int NWR = 2;
   localparam int NRD = 2;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("repl_bank_ram: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("repl_bank_ram: DATA_W must be at least 1");
      end
   endgenerate

   logic              wr_en_v   [NWR];
   logic [ADDR_W-1:0] wr_addr_v [NWR];
   logic [DATA_W-1:0] wr_data_v [NWR];
   logic [ADDR_W-1:0] rd_addr_v [NRD];
   logic [DATA_W-1:0] bank_q    [NWR][NRD];
   logic              side_q    [NWR][NRD];
   logic              peek_v    [NWR];
   logic [DATA_W-1:0] out_q     [NRD];

   assign wr_en_v[0]   = wa_en;
   assign wr_en_v[1]   = wb_en;
   assign wr_addr_v[0] = wa_addr;
   assign wr_addr_v[1] = wb_addr;
   assign wr_data_v[0] = wa_data;
   assign wr_data_v[1] = wb_data;
   assign rd_addr_v[0] = rc_addr;
   assign rd_addr_v[1] = rd_addr;

   generate
      for (genvar w = 0; w < NWR; w++) begin : g_wr
         for (genvar r = 0; r < NRD; r++) begin : g_rd
            rbr_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
               .clk     (clk),
               .rst_n   (rst_n),
               .wr_en   (wr_en_v[w]),
               .wr_addr (wr_addr_v[w]),
               .wr_data (wr_data_v[w]),
               .rd_addr (rd_addr_v[r]),
               .rd_data (bank_q[w][r])
            );
         end

         // Writer B keeps the inverse of A's bit; A copies B's bit.
         rbr_side_store #(.DEPTH(DEPTH), .INVERT(w == 1)) u_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en_v[w]),
            .wr_addr   (wr_addr_v[w]),
            .peer_bit  (peek_v[NWR-1-w]),
            .peek_addr (wr_addr_v[NWR-1-w]),
            .peek_bit  (peek_v[w]),
            .rc_addr   (rd_addr_v[0]),
            .rd_addr   (rd_addr_v[1]),
            .rc_bit    (side_q[w][0]),
            .rd_bit    (side_q[w][1])
         );
      end

      for (genvar r = 0; r < NRD; r++) begin : g_sel
         rbr_read_sel #(.DATA_W(DATA_W)) u_sel (
            .word_a   (bank_q[0][r]),
            .word_b   (bank_q[1][r]),
            .bit_a    (side_q[0][r]),
            .bit_b    (side_q[1][r]),
            .sel_data (out_q[r])
         );
      end
   endgenerate

   assign rc_data = out_q[0];
   assign rd_data = out_q[1];
endmodule

// File: rtl/repl_bank_ram_chk.sv
module repl_bank_ram_chk #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wa_en,
   input logic [ADDR_W-1:0] wa_addr,
   input logic [DATA_W-1:0] wa_data,
   input logic              wb_en,
   input logic [ADDR_W-1:0] wb_addr,
   input logic [DATA_W-1:0] wb_data,
   input logic [ADDR_W-1:0] rc_addr,
   input logic [DATA_W-1:0] rc_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] shadow [DEPTH];
   logic [DATA_W-1:0] exp_c, exp_d;
   logic              any_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
         exp_c  <= '0;
         exp_d  <= '0;
         any_wr <= 1'b0;
      end else begin
         exp_c <= shadow[rc_addr];
         exp_d <= shadow[rd_addr];
         if (wa_en) shadow[wa_addr] <= wa_data;
         if (wb_en) shadow[wb_addr] <= wb_data;
         if (wa_en || wb_en) any_wr <= 1'b1;
      end
   end

   assert_distinct_wr_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_en && wb_en) |-> (wa_addr != wb_addr));

   assert_zero_before_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr |-> (rc_data == '0 && rd_data == '0));

   assert_port_c_current_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rc_data == exp_c);

   assert_port_d_current_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data == exp_d);
endmodule

bind repl_bank_ram repl_bank_ram_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
   .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
   .rc_addr(rc_addr), .rc_data(rc_data),
   .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/repl_bank_ram_tb.sv
module repl_bank_ram_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 16;
   localparam int DATA_W = 8;
   localparam int ADDR_W = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wa_en = 1'b0, wb_en = 1'b0;
   logic [ADDR_W-1:0] wa_addr = '0, wb_addr = '0, rc_addr = '0, rd_addr = '0;
   logic [DATA_W-1:0] wa_data = '0, wb_data = '0;
   logic [DATA_W-1:0] rc_data, rd_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [DATA_W-1:0] ref_mem [DEPTH];
   logic [DATA_W-1:0] exp_c, exp_d;
   string pend_tag;
   bit    pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   repl_bank_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
      .rc_addr(rc_addr), .rc_data(rc_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string tag, input string port,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s port %s actual=%h expected=%h", tag, port, act, exp);
      end
   endtask

   // Called at a falling edge: compare the outputs of the previous request.
   task automatic check_pending();
      if (pend) begin
         check(pend_tag, "C", rc_data, exp_c);
         check(pend_tag, "D", rd_data, exp_d);
      end
      pend = 1'b0;
   endtask

   task automatic cyc(input string tag,
                      input bit ae, input int aa, input int ad,
                      input bit be, input int ba, input int bd,
                      input int ca, input int da);
      @(negedge clk);
      check_pending();
      wa_en = ae; wa_addr = ADDR_W'(aa); wa_data = DATA_W'(ad);
      wb_en = be; wb_addr = ADDR_W'(ba); wb_data = DATA_W'(bd);
      rc_addr = ADDR_W'(ca); rd_addr = ADDR_W'(da);
      exp_c = ref_mem[ca];
      exp_d = ref_mem[da];
      pend_tag = tag;
      pend = 1'b1;
      if (ae) ref_mem[aa] = DATA_W'(ad);
      if (be) ref_mem[ba] = DATA_W'(bd);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "C", rc_data, '0);
      check("R1", "D", rd_data, '0);
      cyc("R1", 0, 0, 0, 0, 0, 0, 3, 9);
      cyc("R1", 0, 0, 0, 0, 0, 0, 15, 0);
      // R3: store through A, then read on both ports
      cyc("R3", 1, 5, 'h5A, 0, 0, 0, 0, 1);
      cyc("R3", 0, 0, 0, 0, 0, 0, 5, 5);
      // R4: store through B
      cyc("R4", 0, 0, 0, 1, 7, 'hB7, 0, 0);
      cyc("R4", 0, 0, 0, 0, 0, 0, 7, 7);
      // R5: ownership of one address alternates between writers
      cyc("R5", 1, 2, 'h11, 0, 0, 0, 2, 2);
      cyc("R5", 0, 0, 0, 1, 2, 'h22, 2, 2);
      cyc("R5", 0, 0, 0, 0, 0, 0, 2, 2);
      cyc("R5", 1, 2, 'h33, 0, 0, 0, 2, 2);
      cyc("R5", 0, 0, 0, 0, 0, 0, 2, 2);
      cyc("R5", 0, 0, 0, 1, 2, 'h44, 2, 2);
      cyc("R5", 0, 0, 0, 1, 2, 'h55, 2, 2);
      cyc("R5", 0, 0, 0, 0, 0, 0, 2, 2);
      // R6: read and write the same address in one cycle
      cyc("R6", 1, 4, 'h44, 0, 0, 0, 4, 4);
      cyc("R2", 0, 0, 0, 1, 4, 'h66, 4, 4);
      cyc("R2", 0, 0, 0, 0, 0, 0, 4, 4);
      // R7: enables low with live address and data
      cyc("R7", 0, 5, 'hFF, 0, 7, 'h00, 5, 7);
      cyc("R7", 0, 0, 0, 0, 0, 0, 5, 7);
      // R8: both writers in one cycle, different addresses
      cyc("R8", 1, 10, 'hAA, 1, 11, 'hBB, 10, 11);
      cyc("R8", 0, 0, 0, 0, 0, 0, 10, 11);
      cyc("R8", 0, 0, 0, 0, 0, 0, 11, 10);
      // R9: independent read addresses
      cyc("R9", 0, 0, 0, 0, 0, 0, 5, 7);
      cyc("R9", 0, 0, 0, 0, 0, 0, 4, 2);
      // Random phase: last writer wins under heavy address reuse (R5)
      for (int n = 0; n < 3000; n++) begin
         int aa, ba;
         bit ae, be;
         ae = 1'($urandom);
         be = 1'($urandom);
         aa = int'($urandom % DEPTH);
         ba = int'($urandom % DEPTH);
         if (ae && be && aa == ba) ba = (ba + 1) % DEPTH;
         cyc("R5", ae, aa, int'($urandom % 256), be, ba, int'($urandom % 256),
             int'($urandom % DEPTH), int'($urandom % DEPTH));
      end
      cyc("R9", 0, 0, 0, 0, 0, 0, 0, 1);
      @(negedge clk);
      check_pending();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule